// File: doc/BRIEF.md
# Half-Duplex RS485 Line-Direction Controller

This block sits next to a UART transmitter and drives the direction of an RS485 line driver without software help. It watches three events from the transmit path: a byte being placed into the holding register or transmit FIFO, the shift register being busy, and the end of a stop bit. From these it decides when the driver must be on, and it holds back the transmitter's next start bit until the driver has had time to switch.

Automatic direction control is switched on by a control bit written through a simple write strobe, or by an external strap pin. When the control bit is set it forces the mode on whatever the pin says. The block also picks the transmit interrupt condition. In standard mode the interrupt is raised when the holding side is empty, even if the shift register is still sending. In automatic mode it is raised only when the shift register has also finished. The baud generator, the shift register and the interrupt controller are not part of this block; they appear only as the handshake signals listed below.

Top module: `rs485_dir_ctl`

## Requirements
- R1: After reset `drv_en` is 0 and the automatic-mode control bit is cleared. With `pin_auto` at 0 and no control write, a `thr_load` pulse leaves `drv_en` at 0 and `tx_start_ok` at 1.
- R2: Automatic mode is active when the control bit is 1, whatever the level of `pin_auto`. When the control bit is 0, automatic mode follows `pin_auto`. The control bit takes the value of `cfg_auto` on a clock edge where `cfg_we` is 1.
- R3: In automatic mode, a clock edge that samples `thr_load` at 1 leaves `drv_en` at 1.
- R4: In automatic mode, `drv_en` goes from 1 to 0 only at a clock edge that samples `stop_done` at 1, `fifo_empty` at 1 and `thr_load` at 0.
- R5: In automatic mode, a `stop_done` with `fifo_empty` at 0, or a `stop_done` together with `thr_load`, leaves `drv_en` at 1. The driver therefore does not toggle between back-to-back characters.
- R6: In automatic mode, `tx_start_ok` is 0 while `drv_en` is 0. It rises GUARD clock edges after `drv_en` rises and stays 1 while `drv_en` stays 1. With GUARD=1 this is one clock later.
- R7: In standard mode, `drv_en` is 0 from the next clock edge on, and `tx_start_ok` is 1.
- R8: In standard mode, `tx_irq` equals `fifo_empty`, whatever the level of `tsr_busy`.
- R9: In automatic mode, `tx_irq` is 1 only when `fifo_empty` is 1 and `tsr_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the automatic-mode control bit |
| cfg_auto | input | 1 | Value written into the control bit |
| pin_auto | input | 1 | External strap enabling automatic mode |
| thr_load | input | 1 | A byte was written into the holding register or FIFO |
| fifo_empty | input | 1 | Holding register and FIFO hold no byte |
| tsr_busy | input | 1 | Shift register is sending a character |
| stop_done | input | 1 | Pulse: the last stop bit has left the shift register |
| drv_en | output | 1 | Driver direction (RTS# level): 1 = transmit |
| tx_start_ok | output | 1 | Transmitter may begin a start bit |
| tx_irq | output | 1 | Transmit interrupt condition |

## Verification
The bench builds the block with GUARD=1, so the permit delay is short enough to count edge by edge against the one-clock rule. It covers all four combinations of control bit and strap pin. For each combination it starts from both driver states and applies every one of the 16 patterns of load, stop-completion, FIFO-empty and shift-busy. This covers every priority between a load and a stop completion, and both interrupt selections. Directed sequences add the reset state, back-to-back characters and the permit timing.

// File: rtl/rs485_dir_ctl.sv
module rs485_dir_ctl #(
  parameter int GUARD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_auto,
  input  logic pin_auto,
  input  logic thr_load,
  input  logic fifo_empty,
  input  logic tsr_busy,
  input  logic stop_done,
  output logic drv_en,
  output logic tx_start_ok,
  output logic tx_irq
);
  localparam int GW = (GUARD < 1) ? 1 : $clog2(GUARD + 1);
  localparam logic [GW-1:0] GMAX = GW'(GUARD);

  logic          auto_bit;
  logic          dir;
  logic [GW-1:0] cnt;
  logic          auto_on;

  assign auto_on = auto_bit | pin_auto;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      auto_bit <= 1'b0;
    else if (cfg_we) auto_bit <= cfg_auto;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        dir <= 1'b0;
    else if (!auto_on)                 dir <= 1'b0;
    else if (thr_load)                 dir <= 1'b1;
    else if (stop_done && fifo_empty)  dir <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cnt <= '0;
    else if (!auto_on || !dir) cnt <= '0;
    else if (cnt != GMAX)     cnt <= cnt + 1'b1;

  assign drv_en      = dir;
  assign tx_start_ok = auto_on ? (dir && cnt == GMAX) : 1'b1;
  assign tx_irq      = fifo_empty && !(auto_on && tsr_busy);
endmodule

module rs485_dir_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_on,
  input logic thr_load,
  input logic fifo_empty,
  input logic tsr_busy,
  input logic stop_done,
  input logic drv_en,
  input logic tx_start_ok,
  input logic tx_irq
);
  // R3
  load_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_on && thr_load |=> drv_en);

  // R4
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) && $past(auto_on) |-> $past(stop_done && fifo_empty && !thr_load));

  // R5
  hold_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_on && drv_en && !(stop_done && fifo_empty) |=> drv_en);

  // R6
  permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_on && tx_start_ok |-> drv_en && $past(drv_en));

  // R7
  std_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(auto_on) |-> !drv_en);

  // R9
  irq_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_on && tsr_busy |-> !tx_irq);
endmodule

bind rs485_dir_ctl rs485_dir_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .auto_on(auto_on), .thr_load(thr_load),
  .fifo_empty(fifo_empty), .tsr_busy(tsr_busy), .stop_done(stop_done),
  .drv_en(drv_en), .tx_start_ok(tx_start_ok), .tx_irq(tx_irq)
);

// File: tb/tb_rs485_dir_ctl.sv
`timescale 1ns/1ps
module tb_rs485_dir_ctl;
  localparam int G = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_auto = 1'b0, pin_auto = 1'b0;
  logic thr_load = 1'b0, fifo_empty = 1'b1, tsr_busy = 1'b0, stop_done = 1'b0;
  logic drv_en, tx_start_ok, tx_irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rs485_dir_ctl #(.GUARD(G)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_auto(cfg_auto),
    .pin_auto(pin_auto), .thr_load(thr_load), .fifo_empty(fifo_empty),
    .tsr_busy(tsr_busy), .stop_done(stop_done), .drv_en(drv_en),
    .tx_start_ok(tx_start_ok), .tx_irq(tx_irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    thr_load = 1'b0; stop_done = 1'b0; fifo_empty = 1'b1; tsr_busy = 1'b0;
  endtask

  task automatic start(input logic [1:0] m);
    rst_n = 1'b0; cfg_we = 1'b0; pin_auto = 1'b0; idle_inputs();
    tick(); tick();
    rst_n = 1'b1;
    cfg_we = 1'b1; cfg_auto = m[0]; pin_auto = m[1];
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    rst_n = 1'b0;
    tick(); tick();
    // R1: reset state
    chk("R1", drv_en, 1'b0);
    chk("R1", tx_start_ok, 1'b1);
    rst_n = 1'b1;
    tick();
    thr_load = 1'b1; fifo_empty = 1'b0;
    tick();
    thr_load = 1'b0;
    tick();
    // R1: control bit cleared, load does nothing
    chk("R1", drv_en, 1'b0);
    chk("R1", tx_start_ok, 1'b1);

    // R2..R9 sweep over mode sources, start state and all status patterns
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 16; v++) begin
          logic au, ld, sd, fe, tb, st, e;
          start(m[1:0]);
          au = (m != 0);
          st = s[0];
          if (st) begin
            thr_load = 1'b1; fifo_empty = 1'b0;
            tick();
            thr_load = 1'b0;
            tick();
          end
          {ld, sd, fe, tb} = v[3:0];
          thr_load = ld; stop_done = sd; fifo_empty = fe; tsr_busy = tb;
          #1;
          if (au) chk("R9", tx_irq, fe & ~tb);
          else    chk("R8", tx_irq, fe);
          tick();
          if (!au) begin
            chk("R7", drv_en, 1'b0);
            chk("R7", tx_start_ok, 1'b1);
          end else begin
            e = ld ? 1'b1 : ((sd && fe) ? 1'b0 : (au & st));
            if (ld)            chk("R3", drv_en, e);
            else if (sd && fe) chk("R4", drv_en, e);
            else if (st)       chk("R5", drv_en, e);
            else               chk("R2", drv_en, e);
          end
          idle_inputs();
        end
      end
    end

    // R6: permit timing
    start(2'b01);
    chk("R6", tx_start_ok, 1'b0);
    thr_load = 1'b1; fifo_empty = 1'b0;
    tick();
    thr_load = 1'b0;
    for (int k = 0; k <= G + 1; k++) begin
      chk("R6", drv_en, 1'b1);
      chk("R6", tx_start_ok, (k >= G) ? 1'b1 : 1'b0);
      tick();
    end
    stop_done = 1'b1; fifo_empty = 1'b1;
    tick();
    stop_done = 1'b0;
    chk("R4", drv_en, 1'b0);
    chk("R6", tx_start_ok, 1'b0);

    // R5: back-to-back characters with pin-enabled mode
    start(2'b10);
    thr_load = 1'b1; fifo_empty = 1'b0;
    tick();
    thr_load = 1'b0;
    for (int c = 0; c < 3; c++) begin
      tsr_busy = 1'b1;
      tick();
      stop_done = 1'b1;
      tick();
      stop_done = 1'b0;
      chk("R5", drv_en, 1'b1);
      chk("R6", tx_start_ok, 1'b1);
    end
    stop_done = 1'b1; thr_load = 1'b1; fifo_empty = 1'b1;
    tick();
    chk("R5", drv_en, 1'b1);
    thr_load = 1'b0; tsr_busy = 1'b0;
    tick();
    chk("R4", drv_en, 1'b0);
    idle_inputs();

    // R2: control bit forces mode while pin low, cleared bit follows pin
    start(2'b01);
    pin_auto = 1'b0;
    thr_load = 1'b1; fifo_empty = 1'b0;
    tick();
    thr_load = 1'b0;
    chk("R2", drv_en, 1'b1);
    cfg_we = 1'b1; cfg_auto = 1'b0;
    tick();
    cfg_we = 1'b0;
    tick();
    chk("R2", drv_en, 1'b0);
    chk("R7", tx_start_ok, 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule